// File: doc/BRIEF.md
# Overload Hiccup Protection Controller

This block supervises an output power stage. It receives an overload level and two temperature levels, all already synchronised to its clock, together with a small control register written through a single write strobe. From these it drives the stage's output enable and its current-limit range select, and it raises an overload flag and an over-temperature flag for the host to watch.

Overload handling takes one of two forms, chosen by a register bit. In static mode the stage stays on and only clamps its current, and the overload flag follows the overload level. In dynamic mode an overload starts a retry cycle. The output is switched off for an off-window and then switched back on for an on-window. The cycle repeats until an on-window passes with no overload. Both window lengths are parameters counted in pulses of a time-base tick input. An over-temperature trip shuts the stage down and wipes the control register. The flag is released only when the cool-down level is reached, which gives hysteresis between trip and release.

Top module: `hiccup_guard`

## Requirements
- R1: After reset the control register reads 0, both flags are low and the output enable is low.
- R2: A write strobe loads the 3-bit control register on the next clock edge (bit 0 = enable, bit 1 = static mode, bit 2 = high current range). `cfgQ` reads it back, and `limitHigh` always equals bit 2.
- R3: In dynamic mode, with the output enabled and soft-start complete, overload seen at a clock edge drives `outEn` low and `ovlFlag` high from that edge on.
- R4: The off-window lasts exactly OFF_TICKS tick pulses. At the edge that samples the last one, `outEn` returns high and the on-window begins.
- R5: If overload is seen at any edge of an on-window, including the edge that closes it, a new off-window starts when the on-window ends, and `ovlFlag` stays high.
- R6: When an on-window of ON_TICKS ticks sees no overload, the controller returns to normal running with `ovlFlag` low and `outEn` high.
- R7: In static mode `ovlFlag` equals the overload level sampled at the previous edge, and overload never drives `outEn` low.
- R8: Once the static-mode bit is stored during a retry cycle, the next edge returns the controller to normal running with `outEn` high.
- R9: While `startDone` is low, overload is ignored and `ovlFlag` reads low. The flag is therefore low when soft-start completes.
- R10: An over-temperature trip seen at an edge sets `otFlag`, clears the control register and drives `outEn` low from that edge on.
- R11: `otFlag` stays high until `otCool` is high while `otTrip` is low. While it is high, register writes are ignored and the register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base pulse that advances the window counter |
| cfgWe | input | 1 | Control register write strobe |
| cfgIn | input | 3 | Control register write data |
| ovl | input | 1 | Synchronised overload level |
| startDone | input | 1 | High once soft-start has completed |
| otTrip | input | 1 | Synchronised over-temperature trip level |
| otCool | input | 1 | Synchronised cool-down reached level |
| outEn | output | 1 | Output stage enable |
| limitHigh | output | 1 | Current-limit range select, high range when 1 |
| ovlFlag | output | 1 | Overload status flag |
| otFlag | output | 1 | Over-temperature status flag |
| cfgQ | output | 3 | Control register read-back |

## Verification
The assertions check on every cycle the local rules of the block. The flag is high throughout an off-window. Static mode or unfinished soft-start forces normal running on the next edge. A trip wipes the register and sets the hot flag. The hot flag holds until cool-down. The window counter stays below its longest window. Window lengths measured in ticks, the repeat or recovery chosen at the end of an on-window, and the ordering of a mode change against a running cycle depend on whole sequences. Only the bench's directed scenarios, and its random runs compared with a cycle model, show those.

// File: rtl/hg_pkg.sv
package hg_pkg;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_OFF = 2'd1,
    ST_ON  = 2'd2
  } hState_t;

  // Bit positions are visible to software: 2 = range, 1 = static, 0 = enable
  typedef struct packed {
    logic rangeHigh;
    logic staticMode;
    logic enable;
  } cfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic useOnLen;
    logic hitClr;
    logic hitSet;
  } strobe_t;

endpackage

// File: rtl/hg_datapath.sv
module hg_datapath
  import hg_pkg::*;
#(
  parameter int OFF_TICKS = 900,
  parameter int ON_TICKS  = 20
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    cfgWe,
  input  cfg_t    cfgIn,
  input  logic    otTrip,
  input  logic    otCool,
  input  strobe_t stb,
  output cfg_t    cfgQ,
  output logic    otFlag,
  output logic    winLast,
  output logic    hitSeen
);

  localparam int MAX_TICKS = (OFF_TICKS > ON_TICKS) ? OFF_TICKS : ON_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_TICKS - 1);
  localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_TICKS - 1);

  logic [CNT_W-1:0] winCnt;

  // Over-temperature flag with trip/release hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        otFlag <= 1'b0;
    else if (otTrip)  otFlag <= 1'b1;
    else if (otCool)  otFlag <= 1'b0;
  end

  // Control register, wiped on trip and held clear while hot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cfgQ <= '0;
    else if (otTrip || otFlag)  cfgQ <= '0;
    else if (cfgWe)             cfgQ <= cfgIn;
  end

  // Window counter in tick pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           winCnt <= '0;
    else if (stb.cntClr) winCnt <= '0;
    else if (tick)       winCnt <= winCnt + 1'b1;
  end

  assign winLast = (winCnt == (stb.useOnLen ? ON_LAST : OFF_LAST));

  // Overload seen during the current on-window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           hitSeen <= 1'b0;
    else if (stb.hitClr) hitSeen <= 1'b0;
    else if (stb.hitSet) hitSeen <= 1'b1;
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    winCnt < CNT_W'(MAX_TICKS));

  p_trip_wipes_r10: assert property (@(posedge clk) disable iff (!rstN)
    otTrip |=> (cfgQ == '0) && otFlag);

  p_hot_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    (otFlag && !otCool) |=> otFlag && (cfgQ == '0));

endmodule

// File: rtl/hg_ctrl.sv
module hg_ctrl
  import hg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    ovl,
  input  logic    startDone,
  input  logic    otTrip,
  input  logic    otFlag,
  input  cfg_t    cfgQ,
  input  logic    winLast,
  input  logic    hitSeen,
  output strobe_t stb,
  output hState_t state,
  output logic    ovlFlag
);

  hState_t nState;
  logic    nFlag;
  logic    winEnd;

  assign winEnd = tick && winLast;

  always_comb begin
    nState       = state;
    nFlag        = ovlFlag;
    stb          = '0;
    stb.useOnLen = (state == ST_ON);
    if (otTrip || otFlag || !cfgQ.enable || !startDone) begin
      nState     = ST_RUN;
      nFlag      = 1'b0;
      stb.cntClr = 1'b1;
      stb.hitClr = 1'b1;
    end else if (cfgQ.staticMode) begin
      nState     = ST_RUN;
      nFlag      = ovl;
      stb.cntClr = 1'b1;
      stb.hitClr = 1'b1;
    end else begin
      case (state)
        ST_RUN: begin
          stb.cntClr = 1'b1;
          stb.hitClr = 1'b1;
          nFlag      = ovl;
          if (ovl) nState = ST_OFF;
        end
        ST_OFF: begin
          nFlag = 1'b1;
          if (winEnd) begin
            nState     = ST_ON;
            stb.cntClr = 1'b1;
            stb.hitClr = 1'b1;
          end
        end
        ST_ON: begin
          nFlag      = 1'b1;
          stb.hitSet = ovl;
          if (winEnd) begin
            stb.cntClr = 1'b1;
            stb.hitClr = 1'b1;
            if (hitSeen || ovl) begin
              nState = ST_OFF;
            end else begin
              nState = ST_RUN;
              nFlag  = 1'b0;
            end
          end
        end
        default: begin
          nState = ST_RUN;
          nFlag  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      ovlFlag <= 1'b0;
    end else begin
      state   <= nState;
      ovlFlag <= nFlag;
    end
  end

  p_flag_in_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF) |-> ovlFlag);

  p_enter_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && ovl && cfgQ.enable && !cfgQ.staticMode && startDone
     && !otTrip && !otFlag) |=> (state == ST_OFF) && ovlFlag);

  p_static_runs_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.staticMode |=> (state == ST_RUN));

  p_softstart_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !startDone |=> !ovlFlag && (state == ST_RUN));

endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
  import hg_pkg::*;
#(
  parameter int OFF_TICKS = 900,
  parameter int ON_TICKS  = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       cfgWe,
  input  logic [2:0] cfgIn,
  input  logic       ovl,
  input  logic       startDone,
  input  logic       otTrip,
  input  logic       otCool,
  output logic       outEn,
  output logic       limitHigh,
  output logic       ovlFlag,
  output logic       otFlag,
  output logic [2:0] cfgQ
);

  cfg_t    cfgReg;
  strobe_t stb;
  hState_t state;
  logic    winLast;
  logic    hitSeen;

  hg_datapath #(.OFF_TICKS(OFF_TICKS), .ON_TICKS(ON_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick),
    .cfgWe(cfgWe), .cfgIn(cfg_t'(cfgIn)),
    .otTrip(otTrip), .otCool(otCool), .stb(stb),
    .cfgQ(cfgReg), .otFlag(otFlag), .winLast(winLast), .hitSeen(hitSeen)
  );

  hg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .ovl(ovl), .startDone(startDone),
    .otTrip(otTrip), .otFlag(otFlag), .cfgQ(cfgReg),
    .winLast(winLast), .hitSeen(hitSeen),
    .stb(stb), .state(state), .ovlFlag(ovlFlag)
  );

  assign outEn     = cfgReg.enable && !otFlag && (state != ST_OFF);
  assign limitHigh = cfgReg.rangeHigh;
  assign cfgQ      = cfgReg;

  p_static_keeps_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReg.staticMode && cfgReg.enable && !otFlag && !otTrip && !cfgWe) |=> outEn);

endmodule

// File: tb/sim_hiccup_guard.sv
module sim_hiccup_guard;

  localparam int CLK_PERIOD = 10;
  localparam int OFF_T = 12;
  localparam int ON_T  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, cfgWe = 1'b0, ovl = 1'b0, startDone = 1'b0;
  logic otTrip = 1'b0, otCool = 1'b0;
  logic [2:0] cfgIn = 3'd0;
  logic outEn, limitHigh, ovlFlag, otFlag;
  logic [2:0] cfgQ;

  int nChk = 0, nBad = 0;

  // Reference model state: 0 run, 1 off-window, 2 on-window
  logic [2:0] mCfg;
  logic mOt, mFlag, mHit;
  int mSt, mCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiccup_guard #(.OFF_TICKS(OFF_T), .ON_TICKS(ON_T)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .cfgWe(cfgWe), .cfgIn(cfgIn),
    .ovl(ovl), .startDone(startDone), .otTrip(otTrip), .otCool(otCool),
    .outEn(outEn), .limitHigh(limitHigh), .ovlFlag(ovlFlag),
    .otFlag(otFlag), .cfgQ(cfgQ)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expOutEn();
    return mCfg[0] && !mOt && (mSt != 1);
  endfunction

  task automatic compareAll();
    chk("R3 R4 R5 R8 outEn", outEn, expOutEn());
    chk("R3 R6 R7 R9 ovlFlag", ovlFlag, mFlag);
    chk("R10 R11 otFlag", otFlag, mOt);
    chk("R2 R10 cfgQ", cfgQ, mCfg);
    chk("R2 limitHigh", limitHigh, mCfg[2]);
  endtask

  // Next model state from the requirements, applied at the clock edge
  task automatic modelEdge();
    logic [2:0] nCfg; logic nOt, nFlag, nHit; int nSt, nCnt;
    logic last;
    nOt  = otTrip ? 1'b1 : (otCool ? 1'b0 : mOt);
    nCfg = (otTrip || mOt) ? 3'd0 : (cfgWe ? cfgIn : mCfg);
    nSt = mSt; nFlag = mFlag; nHit = mHit; nCnt = mCnt;
    last = tick && (mCnt == ((mSt == 2) ? ON_T - 1 : OFF_T - 1));
    if (otTrip || mOt || !mCfg[0] || !startDone) begin
      nSt = 0; nFlag = 0; nHit = 0; nCnt = 0;
    end else if (mCfg[1]) begin
      nSt = 0; nFlag = ovl; nHit = 0; nCnt = 0;
    end else if (mSt == 0) begin
      nCnt = 0; nHit = 0; nFlag = ovl;
      if (ovl) nSt = 1;
    end else begin
      nFlag = 1;
      if (mSt == 2 && ovl) nHit = 1;
      if (tick) nCnt = mCnt + 1;
      if (last) begin
        nCnt = 0; nHit = 0;
        if (mSt == 1) nSt = 2;
        else if (mHit || ovl) nSt = 1;
        else begin nSt = 0; nFlag = 0; end
      end
    end
    @(posedge clk);
    mCfg = nCfg; mOt = nOt; mSt = nSt; mFlag = nFlag; mHit = nHit; mCnt = nCnt;
  endtask

  task automatic step();
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic writeCfg(input logic [2:0] v);
    cfgWe = 1'b1; cfgIn = v;
    step();
    cfgWe = 1'b0;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    mCfg = 0; mOt = 0; mFlag = 0; mHit = 0; mSt = 0; mCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 outEn", outEn, 0);
    chk("R1 ovlFlag", ovlFlag, 0);
    chk("R1 otFlag", otFlag, 0);
    chk("R1 cfgQ", cfgQ, 0);

    // R2 write: enable, dynamic, high range
    writeCfg(3'b101);
    chk("R2 cfgQ", cfgQ, 5);
    chk("R2 limitHigh", limitHigh, 1);
    chk("R2 outEn", outEn, 1);

    // R9 soft-start masks overload
    ovl = 1'b1; steps(4);
    chk("R9 ovlFlag", ovlFlag, 0);
    chk("R9 outEn", outEn, 1);
    startDone = 1'b1; ovl = 1'b0; step();
    chk("R9 flag after start", ovlFlag, 0);

    // R3 overload starts the off-window
    tick = 1'b1; ovl = 1'b1; step(); ovl = 1'b0;
    chk("R3 outEn", outEn, 0);
    chk("R3 ovlFlag", ovlFlag, 1);
    // R4 off-window length
    steps(OFF_T - 1);
    chk("R4 still off", outEn, 0);
    step();
    chk("R4 on-window", outEn, 1);
    // R5 overload in on-window repeats
    step(); ovl = 1'b1; step(); ovl = 1'b0;
    steps(ON_T - 3);
    chk("R5 on before end", outEn, 1);
    step();
    chk("R5 repeat off", outEn, 0);
    chk("R5 flag held", ovlFlag, 1);
    // R6 clean on-window recovers
    steps(OFF_T + ON_T);
    chk("R6 outEn", outEn, 1);
    chk("R6 ovlFlag", ovlFlag, 0);

    // R8 static mid-cycle
    ovl = 1'b1; step(); ovl = 1'b0;
    chk("R8 in off", outEn, 0);
    writeCfg(3'b011);
    step();
    chk("R8 back to run", outEn, 1);

    // R7 static clamp flag follows overload
    ovl = 1'b1; step();
    chk("R7 flag high", ovlFlag, 1);
    chk("R7 outEn kept", outEn, 1);
    ovl = 1'b0; step();
    chk("R7 flag low", ovlFlag, 0);

    // R10 trip
    otTrip = 1'b1; step(); otTrip = 1'b0;
    chk("R10 otFlag", otFlag, 1);
    chk("R10 cfgQ", cfgQ, 0);
    chk("R10 outEn", outEn, 0);
    // R11 hysteresis and ignored writes
    writeCfg(3'b001); steps(3);
    chk("R11 otFlag held", otFlag, 1);
    chk("R11 write ignored", cfgQ, 0);
    otCool = 1'b1; step(); otCool = 1'b0;
    chk("R11 released", otFlag, 0);
    writeCfg(3'b001);
    chk("R11 write after cool", cfgQ, 1);

    // Random phase with fixed seed
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 6000; i++) begin
      tick      = ($urandom % 3) == 0;
      ovl       = ($urandom % 10) < 2;
      cfgWe     = ($urandom % 60) == 0;
      cfgIn     = 3'(($urandom % 8) | 1);
      startDone = ($urandom % 200) != 0;
      otTrip    = ($urandom % 400) == 0;
      otCool    = ($urandom % 20) == 0;
      step();
    end
    finishRun();
  end

endmodule